// File: doc/BRIEF.md
# Bus Cycle Wait-State Ready Controller

This block steps a single bus access through its clock states: T1, T2, T3, zero or more wait states, and then T4. A one-clock start pulse in the idle state opens a cycle. On that same edge the block captures the wait count that was selected for the access and the ready-bypass bit. The count can range over 0 to 15 for peripheral-style accesses. A range-select input narrows it to 0 to 3 for other regions.

When the bypass bit is clear, an external ready line also shapes the length of the cycle. The programmed internal wait states always run to the end before ready is allowed to shorten or stretch the access. Ready is tested at one fixed state. If it is low there, the cycle holds in extra wait states until ready appears. After that, one more wait state is inserted, and then T4. The ready line may change at any time relative to the clock, so it passes through a two-flop synchronizer before it is used.

The outputs are the current state code, a done pulse that marks T4, and a busy flag. A bus interface unit uses these to time its strobes and data capture.

Top module: `bcw_ctrl`

## Requirements
- R1: While reset is low, and on the first sample after reset, `bus_state` is 0 (idle), `cyc_busy` is 0 and `cyc_done` is 0. Asserting reset in the middle of a cycle returns the block to idle.
- R2: A `cyc_start` pulse seen in idle moves the block to T1 on the next clock. T1, T2 and T3 then follow on consecutive clocks. The state codes are idle=0, T1=1, T2=2, T3=3, wait=4 and T4=5.
- R3: When `rdy_bypass` is 1, a cycle lasts exactly 4+N clocks from T1 through T4, where N is the effective wait count. The ready input has no effect in this case.
- R4: When `wide_range` is 1, the effective wait count is `wait_sel` (0..15). When `wide_range` is 0, only `wait_sel[1:0]` is used (0..3) and the upper bits are ignored.
- R5: When ready is required, ready is tested in wait state N-1 if N is 2 or more, and in T3 if N is 0 or 1. If ready is high at that point, the cycle lasts 4+N clocks.
- R6: If ready is low at the test point, the block repeats wait states and tests ready in each one. The first wait state that sees ready high is followed by exactly one more wait state and then T4.
- R7: A rising edge on `rdy_async` during clock k of the cycle is first seen internally in clock k+2. This is the two-stage synchronizer latency.
- R8: `cyc_done` is high for exactly one clock, in T4, and only there. The state after T4 is idle. `cyc_busy` is high in every state other than idle.
- R9: A `cyc_start` pulse while busy is ignored. Changes to `wait_sel`, `wide_range` or `rdy_bypass` after the start do not alter the running cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| cyc_start | input | 1 | One-clock request to begin a bus cycle |
| wait_sel | input | 4 | Programmed wait-state count for this access |
| wide_range | input | 1 | 1: full 0..15 count; 0: count limited to low two bits |
| rdy_bypass | input | 1 | 1: ignore external ready; 0: ready required |
| rdy_async | input | 1 | External ready, active high, asynchronous |
| bus_state | output | 3 | Current state code (0 idle, 1 T1, 2 T2, 3 T3, 4 wait, 5 T4) |
| cyc_done | output | 1 | High for the one clock spent in T4 |
| cyc_busy | output | 1 | High while a cycle is in progress |

## Verification
The cycle length is measured for counts of 0, 1, 2, 3, 9 and 15, with ready bypassed and with ready required. This shows whether the count reaches the sequencer and whether the narrow-range mask drops the upper bits. With ready required, the rising edge of ready is placed exactly two clocks before the test point and then one clock later. This separates correct synchronizer latency and test-point placement from an off-by-one in either. Late edges at several distances show that the extension ends with exactly one trailing wait state. Start pulses and input changes in the middle of a cycle, together with a reset in the middle of a cycle, confirm that a running access is isolated from later requests and that reset returns the block to idle.

// File: rtl/bcw_pkg.sv
`timescale 1ns/1ps
package bcw_pkg;
  localparam int WAIT_W   = 4;
  localparam int NARROW_W = 2;
  localparam int STATE_W  = 3;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_T3   = 3'd3,
    ST_TW   = 3'd4,
    ST_T4   = 3'd5
  } bus_state_e;

  // Effective wait count after the range limit is applied.
  function automatic logic [WAIT_W-1:0] eff_waits(input logic [WAIT_W-1:0] sel,
                                                  input logic wide);
    logic [WAIT_W-1:0] mask;
    mask = wide ? {WAIT_W{1'b1}} : WAIT_W'((1 << NARROW_W) - 1);
    return sel & mask;
  endfunction

  // Short counts test ready in T3 rather than in a wait state.
  function automatic logic test_in_t3(input logic [WAIT_W-1:0] n);
    return n <= WAIT_W'(1);
  endfunction
endpackage

// File: rtl/bcw_sync.sv
`timescale 1ns/1ps
module bcw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  localparam int DEPTH = (STAGES < 1) ? 1 : STAGES;

  logic [DEPTH-1:0] chain;
  logic [DEPTH:0]   shifted;

  assign shifted = {chain, d_async};

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '0;
    else        chain <= shifted[DEPTH-1:0];
  end

  assign q_sync = chain[DEPTH-1];
endmodule

// File: rtl/bcw_cfg.sv
`timescale 1ns/1ps
module bcw_cfg
  import bcw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WAIT_W-1:0] wait_sel,
  input  logic              wide_range,
  input  logic              bypass_in,
  output logic [WAIT_W-1:0] n_waits,
  output logic              bypass
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      n_waits <= '0;
      bypass  <= 1'b1;
    end else if (load) begin
      n_waits <= eff_waits(wait_sel, wide_range);
      bypass  <= bypass_in;
    end
  end
endmodule

// File: rtl/bcw_seq.sv
`timescale 1ns/1ps
module bcw_seq
  import bcw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WAIT_W-1:0] n_waits,
  input  logic              bypass,
  input  logic              rdy,
  output bus_state_e        st,
  output logic              test_pt,
  output logic              late_rdy,
  output logic              ext_mode
);
  bus_state_e        st_nx;
  logic [WAIT_W-1:0] rem, rem_nx;
  logic              ext_nx;

  assign test_pt  = !bypass &&
                    ((st == ST_T3 && test_in_t3(n_waits)) ||
                     (st == ST_TW && !ext_mode && rem == WAIT_W'(2)));
  assign late_rdy = test_pt && !rdy;

  always_comb begin
    st_nx  = st;
    rem_nx = rem;
    ext_nx = ext_mode;
    unique case (st)
      ST_IDLE: if (start) st_nx = ST_T1;
      ST_T1:   st_nx = ST_T2;
      ST_T2:   st_nx = ST_T3;
      ST_T3: begin
        if (late_rdy) begin
          st_nx  = ST_TW;
          ext_nx = 1'b1;
        end else if (n_waits == '0) begin
          st_nx = ST_T4;
        end else begin
          st_nx  = ST_TW;
          rem_nx = n_waits;
        end
      end
      ST_TW: begin
        if (ext_mode) begin
          if (rdy) begin
            ext_nx = 1'b0;
            rem_nx = WAIT_W'(1);
          end
        end else if (late_rdy) begin
          ext_nx = 1'b1;
        end else if (rem <= WAIT_W'(1)) begin
          st_nx = ST_T4;
        end else begin
          rem_nx = rem - WAIT_W'(1);
        end
      end
      ST_T4: begin
        st_nx  = ST_IDLE;
        rem_nx = '0;
        ext_nx = 1'b0;
      end
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      rem      <= '0;
      ext_mode <= 1'b0;
    end else begin
      st       <= st_nx;
      rem      <= rem_nx;
      ext_mode <= ext_nx;
    end
  end
endmodule

// File: rtl/bcw_ctrl.sv
`timescale 1ns/1ps
module bcw_ctrl
  import bcw_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_start,
  input  logic [WAIT_W-1:0] wait_sel,
  input  logic              wide_range,
  input  logic              rdy_bypass,
  input  logic              rdy_async,
  output logic [STATE_W-1:0] bus_state,
  output logic              cyc_done,
  output logic              cyc_busy
);
  bus_state_e        st;
  logic              rdy_s;
  logic              cfg_load;
  logic [WAIT_W-1:0] n_waits;
  logic              bypass_q;
  logic              test_pt;
  logic              late_rdy;
  logic              ext_mode;

  assign cfg_load = cyc_start && (st == ST_IDLE);

  bcw_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (rdy_async),
    .q_sync  (rdy_s)
  );

  bcw_cfg u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (cfg_load),
    .wait_sel   (wait_sel),
    .wide_range (wide_range),
    .bypass_in  (rdy_bypass),
    .n_waits    (n_waits),
    .bypass     (bypass_q)
  );

  bcw_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (cyc_start),
    .n_waits  (n_waits),
    .bypass   (bypass_q),
    .rdy      (rdy_s),
    .st       (st),
    .test_pt  (test_pt),
    .late_rdy (late_rdy),
    .ext_mode (ext_mode)
  );

  assign bus_state = st;
  assign cyc_done  = (st == ST_T4);
  assign cyc_busy  = (st != ST_IDLE);
endmodule

// File: rtl/bcw_ctrl_chk.sv
`timescale 1ns/1ps
module bcw_ctrl_chk
  import bcw_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               cyc_start,
  input logic [STATE_W-1:0] bus_state,
  input logic               cyc_done,
  input logic               cyc_busy,
  input logic               rdy_s,
  input logic               late_rdy,
  input logic               ext_mode
);
  AST_START_TO_T1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_state == 3'd0 && cyc_start) |=> bus_state == 3'd1); // R2
  AST_T1_TO_T2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_state == 3'd1 |=> bus_state == 3'd2); // R2
  AST_T2_TO_T3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_state == 3'd2 |=> bus_state == 3'd3); // R2
  AST_DONE_IN_T4: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_done |-> bus_state == 3'd5); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_done |=> !cyc_done); // R8
  AST_T4_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_state == 3'd5 |=> bus_state == 3'd0 && !cyc_busy); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_state == 3'd0 && !cyc_start) |=> bus_state == 3'd0); // R9
  AST_LATE_EXTENDS: assert property (@(posedge clk) disable iff (!rst_n)
    late_rdy |=> (bus_state == 3'd4 && ext_mode)); // R6
  AST_EXT_TRAILER: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_state == 3'd4 && ext_mode && rdy_s) |=> (bus_state == 3'd4 && !ext_mode)); // R6
  AST_WAIT_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    bus_state == 3'd4 |=> (bus_state == 3'd4 || bus_state == 3'd5)); // R5
endmodule

bind bcw_ctrl bcw_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cyc_start (cyc_start),
  .bus_state (bus_state),
  .cyc_done  (cyc_done),
  .cyc_busy  (cyc_busy),
  .rdy_s     (rdy_s),
  .late_rdy  (late_rdy),
  .ext_mode  (ext_mode)
);

// File: tb/bcw_ctrl_test.sv
`timescale 1ns/1ps
module bcw_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cyc_start = 1'b0;
  logic [3:0] wait_sel = '0;
  logic       wide_range = 1'b1;
  logic       rdy_bypass = 1'b1;
  logic       rdy_async = 1'b0;
  logic [2:0] bus_state;
  logic       cyc_done;
  logic       cyc_busy;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  bcw_ctrl uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .cyc_start  (cyc_start),
    .wait_sel   (wait_sel),
    .wide_range (wide_range),
    .rdy_bypass (rdy_bypass),
    .rdy_async  (rdy_async),
    .bus_state  (bus_state),
    .cyc_done   (cyc_done),
    .cyc_busy   (cyc_busy)
  );

  // wide, count, bypass, ready-rise clock (0 = high before start), mid-cycle poke
  typedef struct packed {
    logic       wide;
    logic [3:0] w;
    logic       byp;
    logic [7:0] r;
    logic       mid;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 4'd0,  1'b1, 8'd0,  1'b0},
    '{1'b1, 4'd3,  1'b1, 8'd0,  1'b0},
    '{1'b1, 4'd15, 1'b1, 8'd0,  1'b0},
    '{1'b0, 4'd15, 1'b1, 8'd0,  1'b0},
    '{1'b0, 4'd6,  1'b1, 8'd0,  1'b0},
    '{1'b1, 4'd2,  1'b0, 8'd0,  1'b0},
    '{1'b1, 4'd2,  1'b0, 8'd2,  1'b0},
    '{1'b1, 4'd2,  1'b0, 8'd3,  1'b0},
    '{1'b1, 4'd0,  1'b0, 8'd1,  1'b0},
    '{1'b1, 4'd0,  1'b0, 8'd5,  1'b0},
    '{1'b1, 4'd1,  1'b0, 8'd1,  1'b0},
    '{1'b1, 4'd1,  1'b0, 8'd2,  1'b0},
    '{1'b1, 4'd9,  1'b0, 8'd9,  1'b0},
    '{1'b1, 4'd9,  1'b0, 8'd12, 1'b0},
    '{1'b1, 4'd9,  1'b1, 8'd30, 1'b0},
    '{1'b1, 4'd4,  1'b1, 8'd0,  1'b1},
    '{1'b1, 4'd2,  1'b0, 8'd6,  1'b1}
  };

  function automatic string row_tag(input int i);
    case (i)
      0, 1, 14:       return "R3";
      2, 3, 4:        return "R4";
      5, 8, 10, 12:   return "R5";
      6:              return "R7";
      7, 9, 11, 13:   return "R6";
      default:        return "R9";
    endcase
  endfunction

  // Expected T1..T4 length, restated from the requirements.
  function automatic int exp_len(input int n, input bit byp, input int r);
    int tp;
    if (byp || r == 0) return 4 + n;
    tp = (n <= 1) ? 3 : n + 2;   // clock index of the ready test
    if (r + 2 <= tp) return 4 + n; // seen in time (two-clock sync)
    return r + 4;                  // seen at r+2, one trailer wait, then T4
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic run_row(input int idx);
    vec_t v;
    int n, expv, got, k;
    v = VECS[idx];
    n = v.wide ? int'(v.w) : int'(v.w & 4'd3);
    expv = exp_len(n, v.byp, int'(v.r));
    @(negedge clk);
    wide_range = v.wide;
    wait_sel   = v.w;
    rdy_bypass = v.byp;
    rdy_async  = (v.r == 8'd0);
    repeat (3) @(negedge clk);
    cyc_start = 1'b1;
    @(negedge clk);
    cyc_start = 1'b0;
    k = 1;
    got = 0;
    while (got == 0 && k < 64) begin
      if (k <= 3) chk(bus_state == 3'(k), "R2", int'(bus_state), k);
      chk(cyc_busy, "R8", int'(cyc_busy), 1);
      if (cyc_done) begin
        chk(bus_state == 3'd5, "R8", int'(bus_state), 5);
        got = k;
      end
      if (v.mid && k == 2) begin
        cyc_start  = 1'b1;
        wait_sel   = ~v.w;
        wide_range = 1'b1;
        rdy_bypass = ~v.byp;
      end
      if (v.mid && k == 3) cyc_start = 1'b0;
      if (k == int'(v.r)) rdy_async = 1'b1;
      @(negedge clk);
      k++;
    end
    chk(got == expv, row_tag(idx), got, expv);
    chk(bus_state == 3'd0 && !cyc_busy && !cyc_done, v.mid ? "R9" : "R8",
        int'(bus_state), 0);
    rdy_async = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk(bus_state == 3'd0 && !cyc_busy && !cyc_done, "R1", int'(bus_state), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(bus_state == 3'd0 && !cyc_busy, "R1", int'(bus_state), 0);

    for (int i = 0; i < NV; i++) run_row(i);

    // Reset in the middle of a cycle returns to idle (R1).
    @(negedge clk);
    wait_sel = 4'd7; wide_range = 1'b1; rdy_bypass = 1'b1;
    cyc_start = 1'b1;
    @(negedge clk);
    cyc_start = 1'b0;
    repeat (4) @(negedge clk);
    chk(bus_state == 3'd4, "R3", int'(bus_state), 4);
    rst_n = 1'b0;
    @(negedge clk);
    chk(bus_state == 3'd0 && !cyc_busy && !cyc_done, "R1", int'(bus_state), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(bus_state == 3'd0, "R1", int'(bus_state), 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule